// File: doc/BRIEF.md
# Eviction-History Reuse Predictor

This block predicts whether a block that has just missed in a cache is likely to be reused, judging by whether it left the cache only recently. The cache reports every block it evicts by presenting the block address with a strobe, and the predictor records that address in a compact membership set. The set is a bit vector addressed by two XOR-fold hashes.

When the cache misses, it presents the missed block address with a second strobe. One cycle later the predictor returns a registered verdict. High reuse means the address appears to be in the set. Low reuse means it is certainly not in the set. The cache can use the verdict to pick an insertion position for the refill.

Because a set built this way cannot forget one member without risking others, the predictor bounds its population as a whole. It counts insertions, and when the count reaches the nominal capacity it empties the entire vector and restarts the count. Two addresses that hash to the same pair of bits are indistinguishable, so false positives occur by design.

Top module: `evict_bloom_predictor`

## Requirements
- R1: An insertion (`evict_valid` high at a clock edge, not the clearing insertion of R5) sets bit H0(`evict_addr`) and bit H1(`evict_addr`) of the 1024-bit vector.
- R2: `pred_valid` is high in exactly the cycles that follow a cycle with `miss_valid` high. With it, `pred_high_reuse` is 1 when bits H0(`miss_addr`) and H1(`miss_addr`) were both set, and 0 otherwise.
- R3: H0(a) is the XOR of the 10-bit slices a[9:0], a[19:10], a[29:20] and the zero-extended a[31:30]. H1(a) is the same fold applied to `a` rotated right by 5 bit positions.
- R4: An address that was never inserted but shares both hash indices with an inserted address predicts high reuse. One example is the inserted address XOR 32'h0000_8020.
- R5: The 256th insertion since reset or since the last clear does not set bits. Instead it empties the whole vector and returns the insertion count to zero, so every test that follows predicts low reuse until new insertions arrive.
- R6: When an insertion and a test occur at the same clock edge, the test sees the vector as it was before that insertion.
- R7: After reset the vector is empty, the insertion count is zero and `pred_valid` is low.
- R8: A test never changes the vector, so repeated tests of an absent address keep predicting low reuse. `pred_high_reuse` is 0 whenever `pred_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evict_valid | input | 1 | An evicted block address is presented |
| evict_addr | input | 32 | Evicted block address |
| miss_valid | input | 1 | A missed block address is presented for testing |
| miss_addr | input | 32 | Missed block address |
| pred_valid | output | 1 | Verdict strobe, one cycle after the test request |
| pred_high_reuse | output | 1 | 1 = predict high reuse, 0 = predict low reuse |

## Verification
A stuck or missing vector bit shows up at the ports on the first test that hashes onto it. The verdict flips one cycle after that test's strobe. A wrong insertion count does not show until the clear boundary: the clear happens early or late, and addresses from before the clear turn up on the verdict one cycle after the next test. The scoreboard models the vector and the count from the hash definitions and the clearing rule. It compares every verdict in the cycle it appears, including traffic that crosses the clear boundary and deliberate hash aliases.

// File: rtl/ebp_pkg.sv
// Package: shared constants and types for the eviction-history reuse predictor.
// Assumes: nothing beyond IEEE 1800-2017.
package ebp_pkg;

    // Hash variant selector: plain fold, or fold after a rotation.
    typedef enum logic [0:0] {
        HASH_DIRECT  = 1'b0,
        HASH_ROTATED = 1'b1
    } hash_kind_e;

    // Verdict encoding on the prediction output.
    typedef enum logic [0:0] {
        REUSE_LOW  = 1'b0,
        REUSE_HIGH = 1'b1
    } reuse_e;

endpackage

// File: rtl/ebp_hash.sv
// Module: ebp_hash
// Folds an address into an index by XOR of consecutive IDX_W-bit slices.
// The final slice is zero-extended. When ROT is non-zero, the address is
// first rotated right by ROT bits.
// Assumes: 0 <= ROT < ADDR_W. Purely combinational.
module ebp_hash #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int ROT    = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    import ebp_pkg::*;

    localparam hash_kind_e KIND = (ROT == 0) ? HASH_DIRECT : HASH_ROTATED;

    logic [ADDR_W-1:0] pre;

    // The parameter picks the pre-fold permutation.
    generate
        if (KIND == HASH_DIRECT) begin : g_direct
            assign pre = addr;
        end else begin : g_rotated
            assign pre = (addr >> ROT) | (addr << (ADDR_W - ROT));
        end
    endgenerate

    // Fold: each address bit toggles index bit (position mod IDX_W).
    always_comb begin
        idx = '0;
        for (int b = 0; b < ADDR_W; b++) begin
            idx[b % IDX_W] = idx[b % IDX_W] ^ pre[b];
        end
    end

endmodule

// File: rtl/ebp_fill_ctr.sv
// Module: ebp_fill_ctr
// Counts insertions into the filter. It raises clr_o combinationally on the
// insertion that would reach CAPACITY, and then returns to zero.
// Assumes: CAPACITY >= 2. Synchronous active-low reset.
module ebp_fill_ctr #(
    parameter int CAPACITY = 256,
    localparam int CNT_W   = $clog2(CAPACITY) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ins_i,
    output logic clr_o
);
    logic [CNT_W-1:0] cnt_q;

    // The clear fires on the insertion that completes the nominal population.
    assign clr_o = ins_i && (cnt_q == CNT_W'(CAPACITY - 1));

    // Advance on each insertion; restart from zero on the clearing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_o) begin
            cnt_q <= '0;
        end else if (ins_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(CAPACITY)); // R5
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> (cnt_q == '0)); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_i && !clr_o) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R5
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_i |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/ebp_bitvec.sv
// Module: ebp_bitvec
// Holds the membership bit vector. It sets NUM_H bits per insertion, empties
// the whole vector on clear, and reports a combinational membership result
// read from the pre-update state.
// Assumes: clr_i only occurs together with ins_i; clear wins over set.
module ebp_bitvec #(
    parameter int IDX_W = 10,
    parameter int NUM_H = 2,
    localparam int VEC_SZ = 1 << IDX_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ins_i,
    input  logic                        clr_i,
    input  logic [NUM_H-1:0][IDX_W-1:0] ins_idx_i,
    input  logic [NUM_H-1:0][IDX_W-1:0] tst_idx_i,
    output logic                        member_o
);
    logic [VEC_SZ-1:0] vec_q;

    // Update the vector: clear the whole set, or mark every hashed position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (clr_i) begin
            vec_q <= '0;
        end else if (ins_i) begin
            for (int h = 0; h < NUM_H; h++) begin
                vec_q[ins_idx_i[h]] <= 1'b1;
            end
        end
    end

    // Membership: every hashed position must be set in the current state.
    always_comb begin
        member_o = 1'b1;
        for (int h = 0; h < NUM_H; h++) begin
            member_o = member_o & vec_q[tst_idx_i[h]];
        end
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ($countones(vec_q) == 0)); // R5

    generate
        for (genvar g = 0; g < NUM_H; g++) begin : g_chk
            AST_INSERT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                (ins_i && !clr_i) |=> vec_q[$past(ins_idx_i[g])]); // R1
        end
    endgenerate

    AST_NO_INSERT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_i |=> $stable(vec_q)); // R8

endmodule

// File: rtl/evict_bloom_predictor.sv
// Module: evict_bloom_predictor (top)
// Reuse predictor. Evicted block addresses go into a two-hash bit-vector set,
// which is cleared after CAPACITY insertions. Missed block addresses are
// tested against the set, and the registered verdict appears one cycle later
// with a strobe.
// Assumes: a test and an insertion at the same edge see the old vector.
module evict_bloom_predictor #(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 10,
    parameter int NUM_H    = 2,
    parameter int ROT_STEP = 5,
    parameter int CAPACITY = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              pred_valid,
    output logic              pred_high_reuse
);
    import ebp_pkg::*;

    logic [NUM_H-1:0][IDX_W-1:0] ins_idx;
    logic [NUM_H-1:0][IDX_W-1:0] tst_idx;
    logic                        clr;
    logic                        member;

    // One hash pair per variant, shared in structure by the insert and test paths.
    generate
        for (genvar g = 0; g < NUM_H; g++) begin : g_hash
            ebp_hash #(
                .ADDR_W (ADDR_W),
                .IDX_W  (IDX_W),
                .ROT    ((g * ROT_STEP) % ADDR_W)
            ) u_ins_hash (
                .addr (evict_addr),
                .idx  (ins_idx[g])
            );
            ebp_hash #(
                .ADDR_W (ADDR_W),
                .IDX_W  (IDX_W),
                .ROT    ((g * ROT_STEP) % ADDR_W)
            ) u_tst_hash (
                .addr (miss_addr),
                .idx  (tst_idx[g])
            );
        end
    endgenerate

    ebp_fill_ctr #(
        .CAPACITY (CAPACITY)
    ) u_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .ins_i (evict_valid),
        .clr_o (clr)
    );

    ebp_bitvec #(
        .IDX_W (IDX_W),
        .NUM_H (NUM_H)
    ) u_vec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_i     (evict_valid),
        .clr_i     (clr),
        .ins_idx_i (ins_idx),
        .tst_idx_i (tst_idx),
        .member_o  (member)
    );

    // Register the verdict and its strobe; the verdict is forced low when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid      <= 1'b0;
            pred_high_reuse <= REUSE_LOW;
        end else begin
            pred_valid      <= miss_valid;
            pred_high_reuse <= (miss_valid && member) ? REUSE_HIGH : REUSE_LOW;
        end
    end

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> pred_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_valid |=> !pred_valid); // R2
    AST_IDLE_VERDICT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |-> !pred_high_reuse); // R8
    AST_CLEAR_THEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !miss_valid) ##1 miss_valid |=> !pred_high_reuse); // R5

endmodule

// File: tb/evict_bloom_predictor_test.sv
// Scoreboard bench. Driver tasks apply stimulus at the falling edge, update a
// reference model of the set and push the expected verdicts. A monitor pops
// and compares the verdicts just after each rising edge.
module evict_bloom_predictor_test;

    localparam int CAP = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evict_valid = 1'b0;
    logic [31:0] evict_addr = '0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_addr = '0;
    logic        pred_valid;
    logic        pred_high_reuse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        bit    exp_high;
        string tag;
    } exp_t;

    exp_t        sb_q[$];
    bit [1023:0] model_vec = '0;
    int          model_cnt = 0;
    bit          mon_en = 1'b0;

    always #2 clk = ~clk;

    evict_bloom_predictor uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .evict_valid     (evict_valid),
        .evict_addr      (evict_addr),
        .miss_valid      (miss_valid),
        .miss_addr       (miss_addr),
        .pred_valid      (pred_valid),
        .pred_high_reuse (pred_high_reuse)
    );

    // Reference hash from R3: fold 10-bit slices, optionally after rotating right by 5.
    function automatic bit [9:0] ref_hash(input bit [31:0] a, input bit rotated);
        bit [31:0] x;
        bit [9:0]  r;
        x = rotated ? ((a >> 5) | (a << 27)) : a;
        r = x[9:0] ^ x[19:10] ^ x[29:20] ^ {8'd0, x[31:30]};
        return r;
    endfunction

    function automatic bit ref_member(input bit [31:0] a);
        return model_vec[ref_hash(a, 1'b0)] && model_vec[ref_hash(a, 1'b1)];
    endfunction

    // One cycle of stimulus. The test sees the pre-insert model state (R6).
    task automatic step(input bit ev, input bit [31:0] ea,
                        input bit mv, input bit [31:0] ma, input string tag);
        exp_t e;
        @(negedge clk);
        evict_valid = ev;
        evict_addr  = ea;
        miss_valid  = mv;
        miss_addr   = ma;
        if (mv) begin
            e.exp_high = ref_member(ma);
            e.tag      = tag;
            sb_q.push_back(e);
        end
        if (ev) begin
            if (model_cnt == CAP - 1) begin
                model_vec = '0;
                model_cnt = 0;
            end else begin
                model_vec[ref_hash(ea, 1'b0)] = 1'b1;
                model_vec[ref_hash(ea, 1'b1)] = 1'b1;
                model_cnt++;
            end
        end
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, '0, "idle");
    endtask

    task automatic do_reset();
        idle();
        @(negedge clk);
        mon_en    = 1'b0;
        rst_n     = 1'b0;
        model_vec = '0;
        model_cnt = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R7: reset state visible at the outputs.
        checks++;
        if (pred_valid !== 1'b0 || pred_high_reuse !== 1'b0) begin
            fails++;
            $display("FAIL R7 reset outputs: actual %b/%b expected 0/0", pred_valid, pred_high_reuse);
        end
        mon_en = 1'b1;
    endtask

    // Monitor: one expected verdict per cycle after a request, none otherwise.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_en) begin
                if (sb_q.size() > 0) begin
                    exp_t e;
                    e = sb_q.pop_front();
                    checks++;
                    if (pred_valid !== 1'b1 || pred_high_reuse !== e.exp_high) begin
                        fails++;
                        $display("FAIL %s: actual valid=%b high=%b expected valid=1 high=%b",
                                 e.tag, pred_valid, pred_high_reuse, e.exp_high);
                    end
                end else begin
                    checks++;
                    if (pred_valid !== 1'b0 || pred_high_reuse !== 1'b0) begin
                        fails++;
                        $display("FAIL R2/R8 idle: actual valid=%b high=%b expected 0/0",
                                 pred_valid, pred_high_reuse);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        #(4 * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit [31:0] hist[$];
        bit [31:0] a;
        do_reset();

        // R2 and R8: an empty set predicts low; repeated tests stay low.
        step(1'b0, '0, 1'b1, 32'h1234_5678, "R2 empty test");
        step(1'b0, '0, 1'b1, 32'h1234_5678, "R8 repeat test");
        step(1'b0, '0, 1'b1, 32'hDEAD_BEEF, "R8 other test");
        idle();

        // R1 and R3: an inserted address then tests high.
        step(1'b1, 32'hCAFE_0040, 1'b0, '0, "ins");
        step(1'b0, '0, 1'b1, 32'hCAFE_0040, "R1 inserted tests high");
        step(1'b0, '0, 1'b1, 32'hCAFE_0041, "R3 neighbour");

        // R6: a same-edge test sees the old vector; the next test sees the insert.
        step(1'b1, 32'h0BAD_F00D, 1'b1, 32'h0BAD_F00D, "R6 same cycle low");
        step(1'b0, '0, 1'b1, 32'h0BAD_F00D, "R6 next cycle high");

        // R4: an alias sharing both indices is a false positive.
        step(1'b1, 32'h7000_1000, 1'b0, '0, "ins");
        step(1'b0, '0, 1'b1, 32'h7000_1000 ^ 32'h0000_8020, "R4 alias high");

        // R5: 255 insertions keep their members; the 256th empties the set.
        do_reset();
        for (int i = 0; i < CAP - 1; i++) begin
            step(1'b1, 32'h0100_0000 + i * 32'h0000_1001, 1'b0, '0, "fill");
        end
        step(1'b0, '0, 1'b1, 32'h0100_0000, "R5 before clear high");
        step(1'b1, 32'h5555_AAAA, 1'b1, 32'h0100_0000, "R5 clearing edge old view");
        step(1'b0, '0, 1'b1, 32'h0100_0000, "R5 after clear low");
        step(1'b0, '0, 1'b1, 32'h5555_AAAA, "R5 clearing address dropped");
        step(1'b1, 32'h0200_0000, 1'b0, '0, "ins");
        step(1'b0, '0, 1'b1, 32'h0200_0000, "R5 count restarted, R1 insert");

        // Mixed traffic across further clear boundaries.
        for (int i = 0; i < 900; i++) begin
            bit ev;
            bit mv;
            ev = ($urandom % 4) != 0;
            mv = ($urandom % 2) != 0;
            a  = $urandom;
            if (mv && hist.size() > 0 && ($urandom % 2) != 0)
                step(ev, a, mv, hist[$urandom % hist.size()], "R2 mixed traffic");
            else
                step(ev, a, mv, $urandom, "R2 mixed traffic");
            if (ev) hist.push_back(a);
            if (hist.size() > 64) void'(hist.pop_front());
        end
        idle();
        idle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule